// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block holds the power state of a small processor subsystem and turns it into clock-gating and power-net controls. It has three states. In run, the core and peripherals are clocked. In idle, the core clock stops while the peripheral clock keeps running. In shutdown, both clocks stop, the internal power nets are commanded off and the pins are held at their last driven value.

Software changes state through a plain register write port and can read its control bits back through a combinational read port. Idle is requested by setting one bit, and any pending interrupt ends it. Shutdown needs two steps: an arm bit in a separate register must be set first, and only then does a stop write take effect. The only ways out of shutdown are the external reset pin and the power-on reset. Both resets act on the next clock edge. The single exception is the pin-hold output, which lets go as soon as either reset is seen. The block has no data stream, so every pin is a plain level or strobe with no handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `por` or `rst_pin` is high at a rising clock edge, the next state is run (`mode` = 0). After that edge, `core_clk_en`=1, `periph_clk_en`=1, `pwr_net_off`=0, `pin_hold`=0, and both registers read 0. Register 0 holds bit0 = idle, bit1 = stop. Register 1 holds bit0 = arm.
- R2: In run, a write to register 0 with bit0 set and no valid shutdown moves the block to idle (`mode` = 1) on the next edge. In idle, `core_clk_en`=0 and `periph_clk_en`=1.
- R3: In idle, any set bit of `irq_pend` at an edge returns the block to run. Register 0 bit0 reads 1 while idle and reads 0 after the wake.
- R4: An interrupt that is already pending when idle is written gives exactly one cycle in idle, followed by run.
- R5: A write to register 0 with bit1 set while the arm bit is 0 does not cause shutdown. The block stays in run, and register 0 bit1 reads 0.
- R6: With arm set, a write to register 0 with bit1 set moves the block to shutdown (`mode` = 2) on the next edge. In shutdown, `core_clk_en`=0, `periph_clk_en`=0, `pwr_net_off`=1, `pin_hold`=1, and register 0 bit1 reads 1.
- R7: In shutdown, interrupts and register writes have no effect, and the block stays in shutdown.
- R8: In shutdown, `rst_pin` or `por` returns the block to run on the next edge, with arm and stop cleared. `pin_hold` drops to 0 as soon as either reset is high, without waiting for an edge.
- R9: An armed write with both bit0 and bit1 set enters shutdown, not idle.
- R10: In run, writes to register 1 set or clear the arm bit, and the new value reads back. Writes made in idle or shutdown change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, active high, acts at the clock edge |
| rst_pin | input | 1 | External reset pin, active high, acts at the clock edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 = mode control, 1 = arm) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| irq_pend | input | IRQ_W | Pending interrupt vector |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pwr_net_off | output | 1 | Internal power nets off command |
| pin_hold | output | 1 | Pin state retention |
| mode | output | 2 | Current state: 0 run, 1 idle, 2 shutdown |

## Verification
The bench sends a stop write while the block is not armed. A design that skipped the arm check would drop the clocks at that point. It puts an interrupt on the bus in the same cycle as the idle write. A design that only looked for a rising interrupt would keep the core halted for good. It raises interrupts and sends writes during shutdown, where a leaky design would wake up. It checks `pin_hold` between asserting the reset and the next edge, where a design that registered the release would still be holding. After the reset it reads the arm and stop bits, where a stale bit would allow a one-write shutdown later.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_OFF  = 2'd2
  } pwr_mode_t;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_ARM  = 1;

  localparam int unsigned CTRL_IDLE_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT = 1;
  localparam int unsigned ARM_BIT       = 0;

endpackage

// File: rtl/pwr_ctrl_regs.sv
module pwr_ctrl_regs
  import pwr_mode_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  pwr_mode_t         cur_mode,
  input  logic              idle_flag,
  input  logic              stop_flag,
  output logic              req_idle,
  output logic              req_stop,
  output logic              arm_q
);

  logic accept;
  logic hit_ctrl;
  logic hit_arm;
  logic unused_wdata;

  assign accept   = wr_en && (cur_mode == MODE_RUN);
  assign hit_ctrl = accept && (wr_addr == ADDR_W'(REG_CTRL));
  assign hit_arm  = accept && (wr_addr == ADDR_W'(REG_ARM));

  assign req_idle = hit_ctrl && wr_data[CTRL_IDLE_BIT];
  assign req_stop = hit_ctrl && wr_data[CTRL_STOP_BIT] && arm_q;

  assign unused_wdata = ^wr_data[DATA_W-1:2];

  always_ff @(posedge clk) begin
    if (rst_any) begin
      arm_q <= 1'b0;
    end else if (hit_arm) begin
      arm_q <= wr_data[ARM_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REG_CTRL)) begin
      rd_data[CTRL_IDLE_BIT] = idle_flag;
      rd_data[CTRL_STOP_BIT] = stop_flag;
    end else if (rd_addr == ADDR_W'(REG_ARM)) begin
      rd_data[ARM_BIT] = arm_q;
    end
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int unsigned IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_any,
  input  logic             req_idle,
  input  logic             req_stop,
  input  logic [IRQ_W-1:0] irq_pend,
  output pwr_mode_t        mode_q,
  output logic             idle_flag,
  output logic             stop_flag
);

  pwr_mode_t mode_d;
  logic      wake;

  assign wake = |irq_pend;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (req_stop) begin
          mode_d = MODE_OFF;
        end else if (req_idle) begin
          mode_d = MODE_IDLE;
        end
      end
      MODE_IDLE: begin
        if (wake) begin
          mode_d = MODE_RUN;
        end
      end
      MODE_OFF: mode_d = MODE_OFF;
      default:  mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      mode_q <= MODE_RUN;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign idle_flag = (mode_q == MODE_IDLE);
  assign stop_flag = (mode_q == MODE_OFF);

endmodule

// File: rtl/pwr_gate_out.sv
module pwr_gate_out
  import pwr_mode_pkg::*;
(
  input  pwr_mode_t mode_q,
  input  logic      rst_any,
  output logic      core_clk_en,
  output logic      periph_clk_en,
  output logic      pwr_net_off,
  output logic      pin_hold
);

  assign core_clk_en   = (mode_q == MODE_RUN);
  assign periph_clk_en = (mode_q != MODE_OFF);
  assign pwr_net_off   = (mode_q == MODE_OFF);
  // Retention lets go as soon as a reset shows up, ahead of the clock edge.
  assign pin_hold      = (mode_q == MODE_OFF) && !rst_any;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IRQ_W  = 4
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IRQ_W-1:0]  irq_pend,
  output logic              core_clk_en,
  output logic              periph_clk_en,
  output logic              pwr_net_off,
  output logic              pin_hold,
  output logic [1:0]        mode
);

  logic      rst_any;
  logic      req_idle;
  logic      req_stop;
  logic      arm_q;
  logic      idle_flag;
  logic      stop_flag;
  pwr_mode_t mode_q;

  assign rst_any = por | rst_pin;
  assign mode    = mode_q;

  pwr_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_any   (rst_any),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cur_mode  (mode_q),
    .idle_flag (idle_flag),
    .stop_flag (stop_flag),
    .req_idle  (req_idle),
    .req_stop  (req_stop),
    .arm_q     (arm_q)
  );

  pwr_mode_fsm #(.IRQ_W(IRQ_W)) u_fsm (
    .clk       (clk),
    .rst_any   (rst_any),
    .req_idle  (req_idle),
    .req_stop  (req_stop),
    .irq_pend  (irq_pend),
    .mode_q    (mode_q),
    .idle_flag (idle_flag),
    .stop_flag (stop_flag)
  );

  pwr_gate_out u_out (
    .mode_q        (mode_q),
    .rst_any       (rst_any),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .pwr_net_off   (pwr_net_off),
    .pin_hold      (pin_hold)
  );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IRQ_W  = 4
) (
  input logic              clk,
  input logic              por,
  input logic              rst_pin,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [IRQ_W-1:0]  irq_pend,
  input logic              arm,
  input logic              core_clk_en,
  input logic              periph_clk_en,
  input logic              pwr_net_off,
  input logic              pin_hold,
  input logic [1:0]        mode
);

  logic rst_any;
  assign rst_any = por | rst_pin;

  assert_reset_to_run_R1: assert property (@(posedge clk)
    rst_any |=> (mode == 2'd0));

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (rst_any)
    (mode == 2'd0 && wr_en && wr_addr == '0 && wr_data[0] && !wr_data[1])
    |=> (mode == 2'd1));

  assert_idle_wake_R3: assert property (@(posedge clk) disable iff (rst_any)
    (mode == 2'd1 && |irq_pend) |=> (mode == 2'd0));

  assert_no_unarmed_stop_R5: assert property (@(posedge clk) disable iff (rst_any)
    (mode == 2'd0 && !arm) |=> (mode != 2'd2));

  assert_off_gating_R6: assert property (@(posedge clk) disable iff (rst_any)
    (mode == 2'd2) |-> (!core_clk_en && !periph_clk_en && pwr_net_off && pin_hold));

  assert_off_sticky_R7: assert property (@(posedge clk) disable iff (rst_any)
    (mode == 2'd2) |=> (mode == 2'd2));

  assert_hold_release_R8: assert property (@(posedge clk)
    rst_any |-> !pin_hold);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)
) u_chk (
  .clk           (clk),
  .por           (por),
  .rst_pin       (rst_pin),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .irq_pend      (irq_pend),
  .arm           (arm_q),
  .core_clk_en   (core_clk_en),
  .periph_clk_en (periph_clk_en),
  .pwr_net_off   (pwr_net_off),
  .pin_hold      (pin_hold),
  .mode          (mode)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int IRQ_W  = 4;

  typedef struct packed {
    logic       we;
    logic [1:0] addr;
    logic [7:0] data;
    logic [3:0] irq;
    logic       rst;
    logic [1:0] exp_mode;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd0, 8'h01, 4'h0, 1'b0, 2'd1}, // R2 idle entry
    '{1'b0, 2'd0, 8'h00, 4'h0, 1'b0, 2'd1}, // R2 idle held
    '{1'b0, 2'd0, 8'h00, 4'h4, 1'b0, 2'd0}, // R3 wake on irq bit 2
    '{1'b1, 2'd0, 8'h02, 4'h0, 1'b0, 2'd0}, // R5 unarmed stop ignored
    '{1'b1, 2'd1, 8'h01, 4'h0, 1'b0, 2'd0}, // R10 set arm
    '{1'b1, 2'd0, 8'h01, 4'h1, 1'b0, 2'd1}, // R4 idle with irq pending
    '{1'b0, 2'd0, 8'h00, 4'h1, 1'b0, 2'd0}, // R4 one cycle idle only
    '{1'b1, 2'd0, 8'h03, 4'h0, 1'b0, 2'd2}, // R9 stop wins over idle
    '{1'b0, 2'd0, 8'h00, 4'hF, 1'b0, 2'd2}, // R7 irq ignored
    '{1'b1, 2'd0, 8'h01, 4'h0, 1'b0, 2'd2}, // R7 write ignored
    '{1'b0, 2'd0, 8'h00, 4'h0, 1'b1, 2'd0}, // R8 pin reset exit
    '{1'b0, 2'd0, 8'h00, 4'h0, 1'b0, 2'd0}  // R8 run after reset
  };

  logic              clk = 1'b0;
  logic              por = 1'b1;
  logic              rst_pin = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic [IRQ_W-1:0]  irq_pend = '0;
  logic              core_clk_en, periph_clk_en, pwr_net_off, pin_hold;
  logic [1:0]        mode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) i_pwr_mode_ctrl (
    .clk(clk), .por(por), .rst_pin(rst_pin), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_pend(irq_pend),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .pwr_net_off(pwr_net_off), .pin_hold(pin_hold), .mode(mode)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic check_gates(input string req, input logic [1:0] m, input bit rst_now);
    check(req, {6'd0, mode}, {6'd0, m});
    check(req, {7'd0, core_clk_en}, {7'd0, m == 2'd0});
    check(req, {7'd0, periph_clk_en}, {7'd0, m != 2'd2});
    check(req, {7'd0, pwr_net_off}, {7'd0, m == 2'd2});
    check(req, {7'd0, pin_hold}, {7'd0, (m == 2'd2) && !rst_now});
  endtask

  task automatic read_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    por = 1'b0;
    step();
    // R1 reset state
    check_gates("R1", 2'd0, 1'b0);
    read_check("R1", 2'd0, 8'h00);
    read_check("R1", 2'd1, 8'h00);

    // vector table walk
    for (int i = 0; i < NVEC; i++) begin
      wr_en    = VEC[i].we;
      wr_addr  = VEC[i].addr;
      wr_data  = VEC[i].data;
      irq_pend = VEC[i].irq;
      rst_pin  = VEC[i].rst;
      if (VEC[i].rst) begin
        #1;
        check("R8 hold release before edge", {7'd0, pin_hold}, 8'h00);
      end
      step();
      wr_en = 1'b0; rst_pin = 1'b0; irq_pend = '0;
      #1;
      check_gates($sformatf("vector %0d", i), VEC[i].exp_mode, 1'b0);
    end
    // R8 arm and stop cleared after reset exit
    read_check("R8", 2'd1, 8'h00);
    read_check("R8", 2'd0, 8'h00);

    // R5 readback of stop after unarmed stop
    do_write(2'd0, 8'h02);
    read_check("R5", 2'd0, 8'h00);
    check_gates("R5", 2'd0, 1'b0);

    // R10 arm set and clear
    do_write(2'd1, 8'h01);
    read_check("R10", 2'd1, 8'h01);
    do_write(2'd1, 8'h00);
    read_check("R10", 2'd1, 8'h00);

    // R3 idle bit readback while idle and after wake; R10 write in idle ignored
    do_write(2'd0, 8'h01);
    read_check("R3", 2'd0, 8'h01);
    do_write(2'd1, 8'h01);
    read_check("R10", 2'd1, 8'h00);
    irq_pend = 4'h8;
    step();
    irq_pend = '0;
    check_gates("R3", 2'd0, 1'b0);
    read_check("R3", 2'd0, 8'h00);

    // R6 arm then stop, exit through power-on reset
    do_write(2'd1, 8'h01);
    do_write(2'd0, 8'h02);
    check_gates("R6", 2'd2, 1'b0);
    read_check("R6", 2'd0, 8'h02);
    por = 1'b1;
    #1;
    check("R8 por hold release", {7'd0, pin_hold}, 8'h00);
    check("R8 still off before edge", {6'd0, mode}, 8'h02);
    step();
    por = 1'b0;
    check_gates("R8", 2'd0, 1'b0);
    read_check("R8", 2'd1, 8'h00);

    // R8 a single stop after reset must not shut down
    do_write(2'd0, 8'h02);
    check_gates("R8 no stale arm", 2'd0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule